// File: doc/BRIEF.md
# Byte-Port 16-bit Timer with Shared High-Byte Latch

This block is a 16-bit up-counter with two 16-bit compare registers. An 8-bit CPU bus reads and writes them one byte at a time. All wide registers share one 8-bit holding latch, so each 16-bit transfer is atomic. A high-byte write only fills the latch, and the following low-byte write commits latch and low byte together. A low-byte read of the counter snapshots the matching high byte into the latch, and the next high-byte read returns that snapshot. Software therefore writes high then low, and reads low then high.

The counter steps once every eight clocks while it runs. In clear-on-match mode the counter climbs to the value held in compare A. On the following step it returns to zero and raises a match flag. In capture mode a capture strobe copies the counter into compare A, which then acts as the capture register and is read through the latch. In narrow mode only the low byte counts.

Top module: `wide_timer_regs`

## Requirements
- R1: A write to a high-byte address (1 counter, 3 compare A, 5 compare B) only loads the latch; the counter and compare registers keep their values.
- R2: A write to a low-byte address (0 counter, 2 compare A, 4 compare B) loads the whole register with {latch, written byte} at that clock edge.
- R3: A read of address 0 returns the counter low byte and copies the counter high byte into the latch at the same edge; a read of address 1 returns the latch.
- R4: With control bit 3 (capture) clear, reads of compare A and compare B return both bytes directly and leave the latch unchanged.
- R5: With control bit 3 set, a one-cycle `cap_strobe` copies the counter into compare A; reading address 2 then loads its high byte into the latch, and reading address 3 returns the latch.
- R6: While control bit 0 (run) is set, the counter advances once every 8 clocks, first on the 8th edge after run is set; clearing run stops it and resets the prescaler phase.
- R7: With control bit 2 (clear-on-match) set, a step taken while the counter equals compare A sets the counter to zero and sets the match flag (address 7 bit 0, also on `match_flag`); in narrow mode only the low bytes are compared.
- R8: Writing a byte with bit 0 set to address 7 clears the match flag; if a match occurs on the same edge, the flag stays set.
- R9: With control bit 1 (wide) clear, the counter steps from 0x00FF to 0x0000, and a counter low-byte write sets the high byte to zero.
- R10: A CPU write to the counter low byte on a step edge wins: the counter takes the written value, not the incremented one.
- R11: After reset the counter, compare registers, latch, control register (address 6), match flag and prescaler phase are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the strobe |
| cap_strobe | input | 1 | Capture event, active for one cycle |
| match_flag | output | 1 | Clear-on-match flag |

## Verification
A latch that loads on the wrong access makes the next high-byte read return a stale or foreign byte. This shows at the port on the second read of a pair. A commit that ignores the latch shows at once on the readback of the written register. A prescaler phase error shifts the step count seen after a fixed number of cycles, which is visible at the first readback after the timer stops. A wrong match or set-versus-clear priority shows on `match_flag` in the cycle after the colliding edge.

// File: rtl/wtr_pkg.sv
// Package: shared widths, register addresses and the control byte layout
// for the byte-port timer. Assumes the word is exactly two bytes.
package wtr_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CNT_LO  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMPA_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMPA_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMPB_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_CMPB_HI = 3'd5;
    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd6;
    localparam logic [ADDR_W-1:0] A_FLAG    = 3'd7;

    // Control byte: bit0 run, bit1 wide, bit2 clear-on-match, bit3 capture.
    typedef struct packed {
        logic [3:0] rsvd;
        logic       capt;
        logic       ctc;
        logic       wide;
        logic       run;
    } ctrl_t;
endpackage

// File: rtl/wtr_prescaler.sv
// Module: divide-by-PRE_DIV step enable. Phase counts only while run is
// set and returns to zero when run is clear. Assumes PRE_DIV >= 2.
module wtr_prescaler #(
    parameter int PRE_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic step
);
    localparam int PRE_BITS = $clog2(PRE_DIV);
    localparam logic [PRE_BITS-1:0] LAST = PRE_BITS'(PRE_DIV - 1);

    logic [PRE_BITS-1:0] phase;

    assign step = run && (phase == LAST);

    // Advance the phase while running, wrap at the last value, clear when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // R6: two steps are never adjacent.
    p_step_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step);
endmodule

// File: rtl/wtr_count.sv
// Module: the timer counter and match flag. Steps on `step`, clears on a
// compare-A hit in clear-on-match mode, wraps at the byte limit in narrow
// mode. A CPU load beats a step; a match beats a flag clear.
module wtr_count
    import wtr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              wide,
    input  logic              ctc,
    input  logic [WORD_W-1:0] top,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    input  logic              flag_clr,
    output logic [WORD_W-1:0] cnt,
    output logic              flag
);
    logic hit;
    logic set_flag;
    logic byte_full;

    assign hit       = wide ? (cnt == top) : (cnt[BYTE_W-1:0] == top[BYTE_W-1:0]);
    assign set_flag  = step && ctc && hit;
    assign byte_full = (cnt[BYTE_W-1:0] == {BYTE_W{1'b1}});

    // Counter update: CPU load first, then match clear, narrow wrap, increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (step) begin
            if (ctc && hit) begin
                cnt <= '0;
            end else if (!wide && byte_full) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Match flag: set has priority over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_flag) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(cnt));
    p_match_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ctc && wide && cnt == top && !load) |=> (cnt == '0 && flag));
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flag && flag_clr) |=> flag);
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !set_flag) |=> !flag);
    p_narrow_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wide && !ctc && !load && cnt == WORD_W'(8'hFF)) |=> cnt == '0);
    p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));
endmodule

// File: rtl/wtr_regs.sv
// Module: byte-wide register port. Holds the shared high-byte latch, the
// two compare registers and the control byte; builds counter loads and the
// read mux. Assumes one strobe per cycle and read data used in that cycle.
module wtr_regs
    import wtr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [WORD_W-1:0] cnt,
    input  logic              flag,
    input  logic              cap_evt,
    output logic [BYTE_W-1:0] rdata,
    output ctrl_t             ctrl,
    output logic [WORD_W-1:0] cmpa,
    output logic              cnt_load,
    output logic [WORD_W-1:0] cnt_load_val,
    output logic              flag_clr
);
    logic [BYTE_W-1:0] latch;
    logic [WORD_W-1:0] cmpb;
    logic              hi_wr;

    assign hi_wr        = wr && (addr == A_CNT_HI || addr == A_CMPA_HI || addr == A_CMPB_HI);
    assign cnt_load     = wr && (addr == A_CNT_LO);
    assign cnt_load_val = {(ctrl.wide ? latch : {BYTE_W{1'b0}}), wdata};
    assign flag_clr     = wr && (addr == A_FLAG) && wdata[0];

    // Shared latch: filled by high writes, or by low reads that snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch <= '0;
        end else if (hi_wr) begin
            latch <= wdata;
        end else if (rd && addr == A_CNT_LO) begin
            latch <= cnt[WORD_W-1:BYTE_W];
        end else if (rd && addr == A_CMPA_LO && ctrl.capt) begin
            latch <= cmpa[WORD_W-1:BYTE_W];
        end
    end

    // Compare A: CPU commit on low write, otherwise capture of the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmpa <= '0;
        end else if (wr && addr == A_CMPA_LO) begin
            cmpa <= {latch, wdata};
        end else if (ctrl.capt && cap_evt) begin
            cmpa <= cnt;
        end
    end

    // Compare B and control byte: plain CPU-written registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmpb <= '0;
            ctrl <= '0;
        end else if (wr) begin
            if (addr == A_CMPB_LO) cmpb <= {latch, wdata};
            if (addr == A_CTRL)    ctrl <= ctrl_t'(wdata);
        end
    end

    // Read mux: counter high and capture high come through the latch.
    always_comb begin
        unique case (addr)
            A_CNT_LO:  rdata = cnt[BYTE_W-1:0];
            A_CNT_HI:  rdata = latch;
            A_CMPA_LO: rdata = cmpa[BYTE_W-1:0];
            A_CMPA_HI: rdata = ctrl.capt ? latch : cmpa[WORD_W-1:BYTE_W];
            A_CMPB_LO: rdata = cmpb[BYTE_W-1:0];
            A_CMPB_HI: rdata = cmpb[WORD_W-1:BYTE_W];
            A_CTRL:    rdata = ctrl;
            default:   rdata = {{(BYTE_W-1){1'b0}}, flag};
        endcase
    end

    p_hi_wr_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> latch == $past(wdata));
    p_lo_wr_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_CMPB_LO) |=> cmpb == {$past(latch), $past(wdata)});
    p_lo_rd_snapshot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && addr == A_CNT_LO) |=> latch == $past(cnt[WORD_W-1:BYTE_W]));
    p_cmp_rd_keeps_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && !ctrl.capt && (addr == A_CMPA_LO || addr == A_CMPB_LO)) |=> $stable(latch));
    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.capt && cap_evt && !(wr && addr == A_CMPA_LO)) |=> cmpa == $past(cnt));
endmodule

// File: rtl/wide_timer_regs.sv
// Module: top of the byte-port 16-bit timer. Wires the prescaler, the
// counter and the register port. Assumes a synchronous single-master bus.
module wide_timer_regs
    import wtr_pkg::*;
#(
    parameter int PRE_DIV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              cap_strobe,
    output logic              match_flag
);
    ctrl_t             ctrl;
    logic              step;
    logic [WORD_W-1:0] cnt;
    logic [WORD_W-1:0] cmpa;
    logic              cnt_load;
    logic [WORD_W-1:0] cnt_load_val;
    logic              flag_clr;

    wtr_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (ctrl.run),
        .step (step)
    );

    wtr_count u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .wide    (ctrl.wide),
        .ctc     (ctrl.ctc),
        .top     (cmpa),
        .load    (cnt_load),
        .load_val(cnt_load_val),
        .flag_clr(flag_clr),
        .cnt     (cnt),
        .flag    (match_flag)
    );

    wtr_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (bus_addr),
        .wr          (bus_wr),
        .rd          (bus_rd),
        .wdata       (bus_wdata),
        .cnt         (cnt),
        .flag        (match_flag),
        .cap_evt     (cap_strobe),
        .rdata       (bus_rdata),
        .ctrl        (ctrl),
        .cmpa        (cmpa),
        .cnt_load    (cnt_load),
        .cnt_load_val(cnt_load_val),
        .flag_clr    (flag_clr)
    );

    // R1: a counter high-byte write alone never moves the counter.
    p_hi_wr_keeps_cnt_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CNT_HI && !step) |=> $stable(cnt));
endmodule

// File: tb/test_wide_timer_regs.sv
// Directed bench: one task per scenario, each checking its own results.
module test_wide_timer_regs;
    logic       clk;
    logic       rst_n;
    logic [2:0] bus_addr;
    logic       bus_wr;
    logic       bus_rd;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       cap_strobe;
    logic       match_flag;

    int checks   = 0;
    int failures = 0;

    localparam logic [7:0] RUN = 8'h01, WIDE = 8'h02, CTC = 8'h04, CAPT = 8'h08;

    wide_timer_regs i_wide_timer_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_strobe(cap_strobe), .match_flag(match_flag)
    );

    initial begin
        clk = 1'b0;
        forever #5 clk = ~clk;
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic expect_rd(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    // Start at edge E0, stop at edge E(8n+3): exactly n steps.
    task automatic run_steps(input logic [7:0] mode, input int n);
        wr(3'd6, mode | RUN);
        repeat (8 * n + 1) @(negedge clk);
        wr(3'd6, mode);
    endtask

    task automatic t_reset;
        check("R11 flag port", {7'b0, match_flag}, 8'h00);
        expect_rd("R11 latch", 3'd1, 8'h00);
        expect_rd("R11 cnt lo", 3'd0, 8'h00);
        expect_rd("R11 cmpa lo", 3'd2, 8'h00);
        expect_rd("R11 cmpb hi", 3'd5, 8'h00);
        expect_rd("R11 ctrl", 3'd6, 8'h00);
        expect_rd("R11 flag", 3'd7, 8'h00);
    endtask

    task automatic t_wide_write;
        wr(3'd6, WIDE);
        wr(3'd1, 8'h12);
        wr(3'd0, 8'h34);
        expect_rd("R2 cnt lo", 3'd0, 8'h34);
        expect_rd("R2 cnt hi", 3'd1, 8'h12);
        wr(3'd1, 8'hAB);
        expect_rd("R1 cnt lo kept", 3'd0, 8'h34);
        expect_rd("R1 cnt hi kept", 3'd1, 8'h12);
        wr(3'd5, 8'hC3);
        wr(3'd4, 8'h3C);
        expect_rd("R2 cmpb lo", 3'd4, 8'h3C);
        expect_rd("R2 cmpb hi", 3'd5, 8'hC3);
    endtask

    task automatic t_atomic_read;
        wr(3'd1, 8'h12);
        wr(3'd0, 8'hFF);
        expect_rd("R3 lo before step", 3'd0, 8'hFF);
        run_steps(WIDE, 1);
        expect_rd("R3 hi snapshot", 3'd1, 8'h12);
        expect_rd("R6 one step lo", 3'd0, 8'h00);
        expect_rd("R3 hi fresh", 3'd1, 8'h13);
    endtask

    task automatic t_cmp_direct;
        wr(3'd3, 8'h56);
        wr(3'd2, 8'h78);
        wr(3'd1, 8'h99);
        expect_rd("R4 cmpa hi direct", 3'd3, 8'h56);
        expect_rd("R4 cmpa lo", 3'd2, 8'h78);
        expect_rd("R4 cmpb lo", 3'd4, 8'h3C);
        wr(3'd0, 8'h00);
        expect_rd("R4 cnt lo", 3'd0, 8'h00);
        expect_rd("R4 latch untouched", 3'd1, 8'h99);
    endtask

    task automatic t_match;
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h00);
        wr(3'd3, 8'h00);
        wr(3'd2, 8'h05);
        run_steps(WIDE | CTC, 5);
        expect_rd("R6 five steps", 3'd0, 8'h05);
        expect_rd("R7 no flag at top", 3'd7, 8'h00);
        run_steps(WIDE | CTC, 1);
        expect_rd("R7 back to zero lo", 3'd0, 8'h00);
        expect_rd("R7 back to zero hi", 3'd1, 8'h00);
        expect_rd("R7 flag reg", 3'd7, 8'h01);
        check("R7 flag port", {7'b0, match_flag}, 8'h01);
    endtask

    task automatic t_flag_clear;
        wr(3'd7, 8'h00);
        expect_rd("R8 zero write no clear", 3'd7, 8'h01);
        wr(3'd7, 8'h01);
        expect_rd("R8 cleared", 3'd7, 8'h00);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h05);
        wr(3'd6, WIDE | CTC | RUN);
        repeat (6) @(negedge clk);
        wr(3'd7, 8'h01);
        wr(3'd6, WIDE | CTC);
        expect_rd("R8 set wins", 3'd7, 8'h01);
        expect_rd("R8 cnt wrapped", 3'd0, 8'h00);
        wr(3'd7, 8'h01);
    endtask

    task automatic t_narrow;
        wr(3'd6, 8'h00);
        wr(3'd1, 8'h12);
        wr(3'd0, 8'hFF);
        expect_rd("R9 lo", 3'd0, 8'hFF);
        expect_rd("R9 hi zero", 3'd1, 8'h00);
        run_steps(8'h00, 1);
        expect_rd("R9 wrap lo", 3'd0, 8'h00);
        expect_rd("R9 wrap hi", 3'd1, 8'h00);
    endtask

    task automatic t_load_wins;
        wr(3'd6, WIDE);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h00);
        wr(3'd6, WIDE | RUN);
        repeat (6) @(negedge clk);
        wr(3'd0, 8'h40);
        wr(3'd6, WIDE);
        expect_rd("R10 load beats step", 3'd0, 8'h40);
        expect_rd("R10 hi", 3'd1, 8'h00);
    endtask

    task automatic t_capture;
        wr(3'd6, WIDE | CAPT);
        wr(3'd1, 8'h01);
        wr(3'd0, 8'h02);
        @(negedge clk); cap_strobe = 1'b1;
        @(negedge clk); cap_strobe = 1'b0;
        wr(3'd1, 8'h77);
        expect_rd("R5 hi via latch", 3'd3, 8'h77);
        expect_rd("R5 capture lo", 3'd2, 8'h02);
        expect_rd("R5 capture hi", 3'd3, 8'h01);
    endtask

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_wdata = '0; cap_strobe = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_wide_write();
        t_atomic_read();
        t_cmp_direct();
        t_match();
        t_flag_clear();
        t_narrow();
        t_load_wins();
        t_capture();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog all actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule